// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block turns one transaction request into the ordered list of bus operations a bit-level I2C engine carries out. It handles START, STOP, bit writes, bit reads and line release. A request names the direction, a 7-bit or 10-bit target address, a byte count, and two options: skip the opening START and address, or skip the closing STOP. A request can instead ask for a register access, with an 8-bit or 16-bit register pointer written ahead of the data.

Write data enters through a byte-wide valid/ready port and read data leaves through another one. The sequencer frames every byte and checks the acknowledge bit. On the first fault it stops the transfer, releases the lines and reports one result code. Bit timing, clock stretching and bus recovery live in the engine and in a recovery unit. The sequencer sees those only as per-command status and a busy input.

Top module: `i2c_txn_sequencer`

## Requirements
- R1: Each byte written is sent as eight bit-write commands, most significant bit first, followed by one bit-read command. A low ninth bit is an acknowledge and a high ninth bit is a negative acknowledge.
- R2: For a 7-bit address the address byte is the address shifted up by one place, with bit 0 set to 1 for a read and 0 for a write.
- R3: For a 10-bit address two bytes are sent. The first is 0xF0 with address bits 9:8 placed in bits 2:1 and the direction flag in bit 0. The second is address bits 7:0.
- R4: With the skip-START option set, neither a START nor any address byte is issued. With the skip-STOP option set, no STOP is issued at the end.
- R5: A read receives each byte as eight bit-read commands and then writes one acknowledge bit: 0 after every byte except the last, 1 after the last. Bytes appear on the read port in bus order, and the acknowledge bit is not issued until that byte has been taken. While a byte waits, the read port holds it stable.
- R6: A negative acknowledge on an address byte ends the transfer with code 1 (no device). One on a pointer or data byte ends it with code 2. In both cases the next command is a release and no STOP follows.
- R7: A register read is START, address with the write flag, pointer, a second START, address with the read flag, data, STOP. A register write is START, address with the write flag, pointer, data, STOP, with no START between pointer and data.
- R8: A 16-bit pointer is sent high byte first. A register request that also sets skip-START or skip-STOP ends with code 5 and issues no bus command.
- R9: A STOP that returns timeout status gives code 3 and no release. Lost arbitration on any command gives code 4. A timeout on any other command gives code 3. Each fault other than a STOP fault is followed by one release command.
- R10: A request is taken only while the sequencer is idle and the recovery-busy input is low. The cycle after a request is taken, no further request is taken.
- R11: Each taken request produces exactly one single-cycle result pulse, with code 0 on success. A bus command stays stable until the engine reports it done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_read | input | 1 | 1 = read data, 0 = write data |
| req_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| req_addr10 | input | 1 | Use 10-bit addressing |
| req_len | input | LEN_W | Number of data bytes |
| req_no_start | input | 1 | Skip START and address phase |
| req_no_stop | input | 1 | Skip final STOP |
| req_reg | input | 1 | Register access request |
| req_reg16 | input | 1 | Register pointer is 16 bits |
| req_reg_ptr | input | 16 | Register pointer value |
| rec_busy | input | 1 | Recovery unit busy |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Consumer takes received byte |
| res_valid | output | 1 | Result pulse |
| res_code | output | 3 | 0 ok, 1 no device, 2 nack, 3 timeout, 4 retry, 5 unsupported |
| bus_cmd_valid | output | 1 | Command to the bit engine present |
| bus_cmd | output | 3 | 0 start, 1 stop, 2 write bit, 3 read bit, 4 release |
| bus_cmd_bit | output | 1 | Bit value for a write-bit command |
| bus_cmd_done | input | 1 | Engine finished the current command |
| bus_rx_bit | input | 1 | Bit sampled by a read-bit command |
| bus_status | input | 2 | 0 ok, 1 clock-stretch timeout, 2 arbitration lost |

## Verification
The checks that run on every cycle cover several handshake and ordering rules. A bus command must hold still until the engine completes it. A waiting received byte must stay stable. A result pulse lasts one cycle. No request is taken in the cycle after one is taken. An abort path issues only release commands. A rejected register request issues no command. The exact byte framing needs the bench's scenarios, which compare the full command stream against a model: MSB order, address encodings, the acknowledge pattern on reads, the register-access sequences and the error-to-code mapping for each fault position.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // command codes toward the bit engine
  localparam logic [2:0] BC_START   = 3'd0;
  localparam logic [2:0] BC_STOP    = 3'd1;
  localparam logic [2:0] BC_WBIT    = 3'd2;
  localparam logic [2:0] BC_RBIT    = 3'd3;
  localparam logic [2:0] BC_RELEASE = 3'd4;

  // engine status
  localparam logic [1:0] BS_OK      = 2'd0;
  localparam logic [1:0] BS_TIMEOUT = 2'd1;

  // transaction result codes
  localparam logic [2:0] RC_OK      = 3'd0;
  localparam logic [2:0] RC_NODEV   = 3'd1;
  localparam logic [2:0] RC_NACK    = 3'd2;
  localparam logic [2:0] RC_TIMEOUT = 3'd3;
  localparam logic [2:0] RC_RETRY   = 3'd4;
  localparam logic [2:0] RC_UNSUP   = 3'd5;

  typedef enum logic [2:0] {
    OP_START, OP_STOP, OP_RELEASE, OP_WBYTE, OP_RBYTE
  } op_e;

  typedef enum logic [1:0] {
    OR_OK, OR_NACK, OR_TIMEOUT, OR_ARB
  } opres_e;

endpackage

// File: rtl/i2cseq_addr_enc.sv
module i2cseq_addr_enc (
  input  logic [9:0] addr,
  input  logic       ten_bit,
  input  logic       rd,
  output logic [7:0] byte1,
  output logic [7:0] byte2
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    if (ten_bit) byte1 = {TEN_PREFIX, addr[9:8], rd};
    else         byte1 = {addr[6:0], rd};
    byte2 = addr[7:0];
  end
endmodule

// File: rtl/i2cseq_op_unit.sv
module i2cseq_op_unit
  import i2cseq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_go,
  input  op_e               op_sel,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              nack_last,
  input  logic              rx_release,
  output logic              op_idle,
  output logic              op_fin,
  output opres_e            op_res,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_hold,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic              cmd_wbit,
  input  logic              cmd_done,
  input  logic              cmd_rbit,
  input  logic [1:0]        cmd_stat
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);

  typedef enum logic [1:0] {U_IDLE, U_ONE, U_BITS, U_HOLD} ust_e;

  ust_e              ust_q, ust_d;
  op_e               op_q, op_d;
  logic [BYTE_W-1:0] shr_q, shr_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              nack_q, nack_d;
  logic              stat_bad;
  opres_e            stat_res;

  always_comb begin
    stat_bad = cmd_done && (cmd_stat != BS_OK);
    stat_res = (cmd_stat == BS_TIMEOUT) ? OR_TIMEOUT : OR_ARB;
  end

  always_comb begin
    ust_d  = ust_q;
    op_d   = op_q;
    shr_d  = shr_q;
    bit_d  = bit_q;
    nack_d = nack_q;
    op_fin = 1'b0;
    op_res = OR_OK;
    case (ust_q)
      U_IDLE: if (op_go) begin
        op_d   = op_sel;
        bit_d  = '0;
        nack_d = nack_last;
        shr_d  = (op_sel == OP_WBYTE) ? tx_byte : '0;
        ust_d  = (op_sel == OP_WBYTE || op_sel == OP_RBYTE) ? U_BITS : U_ONE;
      end
      U_ONE: if (cmd_done) begin
        op_fin = 1'b1;
        op_res = stat_bad ? stat_res : OR_OK;
        ust_d  = U_IDLE;
      end
      U_BITS: if (cmd_done) begin
        if (stat_bad) begin
          op_fin = 1'b1;
          op_res = stat_res;
          ust_d  = U_IDLE;
        end else if (bit_q == ACK_SLOT) begin
          op_fin = 1'b1;
          op_res = (op_q == OP_WBYTE && cmd_rbit) ? OR_NACK : OR_OK;
          ust_d  = U_IDLE;
        end else begin
          bit_d = bit_q + 1'b1;
          shr_d = {shr_q[BYTE_W-2:0], (op_q == OP_RBYTE) ? cmd_rbit : 1'b0};
          if (op_q == OP_RBYTE && bit_q == LAST_DATA) ust_d = U_HOLD;
        end
      end
      U_HOLD: if (rx_release) ust_d = U_BITS;
      default: ust_d = U_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ust_q  <= U_IDLE;
      op_q   <= OP_START;
      shr_q  <= '0;
      bit_q  <= '0;
      nack_q <= 1'b0;
    end else begin
      ust_q  <= ust_d;
      op_q   <= op_d;
      shr_q  <= shr_d;
      bit_q  <= bit_d;
      nack_q <= nack_d;
    end
  end

  always_comb begin
    op_idle   = (ust_q == U_IDLE);
    rx_hold   = (ust_q == U_HOLD);
    rx_byte   = shr_q;
    cmd_valid = (ust_q == U_ONE) || (ust_q == U_BITS);
    cmd_wbit  = 1'b1;
    cmd_code  = BC_RELEASE;
    if (ust_q == U_ONE) begin
      case (op_q)
        OP_START: cmd_code = BC_START;
        OP_STOP:  cmd_code = BC_STOP;
        default:  cmd_code = BC_RELEASE;
      endcase
    end else if (ust_q == U_BITS) begin
      if (bit_q == ACK_SLOT) begin
        cmd_code = (op_q == OP_WBYTE) ? BC_RBIT : BC_WBIT;
        cmd_wbit = (op_q == OP_WBYTE) ? 1'b1 : nack_q;
      end else begin
        cmd_code = (op_q == OP_WBYTE) ? BC_WBIT : BC_RBIT;
        cmd_wbit = (op_q == OP_WBYTE) ? shr_q[BYTE_W-1] : 1'b1;
      end
    end
  end

  // R11: a command holds until the engine completes it
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_code) && $stable(cmd_wbit));

endmodule

// File: rtl/i2c_txn_sequencer.sv
module i2c_txn_sequencer
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic [9:0]       req_addr,
  input  logic             req_addr10,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_no_start,
  input  logic             req_no_stop,
  input  logic             req_reg,
  input  logic             req_reg16,
  input  logic [15:0]      req_reg_ptr,
  input  logic             rec_busy,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             res_valid,
  output logic [2:0]       res_code,
  output logic             bus_cmd_valid,
  output logic [2:0]       bus_cmd,
  output logic             bus_cmd_bit,
  input  logic             bus_cmd_done,
  input  logic             bus_rx_bit,
  input  logic [1:0]       bus_status
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  typedef enum logic [3:0] {
    T_IDLE, T_START, T_ADR1, T_ADR2, T_PTRH, T_PTRL, T_DATA, T_STOP, T_ABORT, T_DONE
  } tst_e;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  tst_e             st_q, st_d;
  logic             rd_q, rd_d, ten_q, ten_d, nostop_q, nostop_d;
  logic             reg_q, reg_d, reg16_q, reg16_d, pass2_q, pass2_d;
  logic [9:0]       addr_q, addr_d;
  logic [15:0]      ptr_q, ptr_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [2:0]       code_q, code_d;

  logic       op_go, op_idle, op_fin, nack_last;
  op_e        op_sel;
  opres_e     op_res;
  logic [7:0] tx_byte, adr_b1, adr_b2;
  tst_e       after_addr;
  logic       addr_rd;

  function automatic logic [2:0] map_res(opres_e r, logic at_addr);
    case (r)
      OR_NACK:    return at_addr ? RC_NODEV : RC_NACK;
      OR_TIMEOUT: return RC_TIMEOUT;
      OR_ARB:     return RC_RETRY;
      default:    return RC_OK;
    endcase
  endfunction

  assign addr_rd = reg_q ? pass2_q : rd_q;

  i2cseq_addr_enc u_addr (
    .addr(addr_q), .ten_bit(ten_q), .rd(addr_rd), .byte1(adr_b1), .byte2(adr_b2)
  );

  always_comb begin
    if (reg_q && !pass2_q) after_addr = reg16_q ? T_PTRH : T_PTRL;
    else                   after_addr = T_DATA;
  end

  always_comb begin
    st_d = st_q;  rd_d = rd_q;  ten_d = ten_q;  nostop_d = nostop_q;
    reg_d = reg_q;  reg16_d = reg16_q;  pass2_d = pass2_q;
    addr_d = addr_q;  ptr_d = ptr_q;  cnt_d = cnt_q;  code_d = code_q;
    op_go = 1'b0;  op_sel = OP_START;  tx_byte = 8'h00;  nack_last = 1'b0;
    wr_ready = 1'b0;  res_valid = 1'b0;  res_code = code_q;
    req_ready = (st_q == T_IDLE) && !rec_busy;
    case (st_q)
      T_IDLE: if (req_valid && req_ready) begin
        rd_d = req_read;  ten_d = req_addr10;  nostop_d = req_no_stop;
        reg_d = req_reg;  reg16_d = req_reg16;  pass2_d = 1'b0;
        addr_d = req_addr;  ptr_d = req_reg_ptr;  cnt_d = req_len;  code_d = RC_OK;
        if (req_reg && (req_no_start || req_no_stop)) begin
          code_d = RC_UNSUP;
          st_d   = T_DONE;
        end else if (!req_reg && req_no_start) st_d = T_DATA;
        else                                   st_d = T_START;
      end
      T_START: begin
        op_go = op_idle;  op_sel = OP_START;
        if (op_fin) begin
          if (op_res != OR_OK) begin code_d = map_res(op_res, 1'b0); st_d = T_ABORT; end
          else st_d = T_ADR1;
        end
      end
      T_ADR1, T_ADR2: begin
        op_go = op_idle;  op_sel = OP_WBYTE;
        tx_byte = (st_q == T_ADR1) ? adr_b1 : adr_b2;
        if (op_fin) begin
          if (op_res != OR_OK) begin code_d = map_res(op_res, 1'b1); st_d = T_ABORT; end
          else if (st_q == T_ADR1 && ten_q) st_d = T_ADR2;
          else st_d = after_addr;
        end
      end
      T_PTRH, T_PTRL: begin
        op_go = op_idle;  op_sel = OP_WBYTE;
        tx_byte = (st_q == T_PTRH) ? ptr_q[15:8] : ptr_q[7:0];
        if (op_fin) begin
          if (op_res != OR_OK) begin code_d = map_res(op_res, 1'b0); st_d = T_ABORT; end
          else if (st_q == T_PTRH) st_d = T_PTRL;
          else if (rd_q) begin pass2_d = 1'b1; st_d = T_START; end
          else st_d = T_DATA;
        end
      end
      T_DATA: begin
        if (cnt_q == '0) st_d = nostop_q ? T_DONE : T_STOP;
        else begin
          op_sel    = rd_q ? OP_RBYTE : OP_WBYTE;
          tx_byte   = wr_data;
          nack_last = (cnt_q == LEN_ONE);
          op_go     = op_idle && (rd_q || wr_valid);
          wr_ready  = op_go && !rd_q;
          if (op_fin) begin
            if (op_res != OR_OK) begin code_d = map_res(op_res, 1'b0); st_d = T_ABORT; end
            else cnt_d = cnt_q - LEN_ONE;
          end
        end
      end
      T_STOP: begin
        op_go = op_idle;  op_sel = OP_STOP;
        if (op_fin) begin code_d = map_res(op_res, 1'b0); st_d = T_DONE; end
      end
      T_ABORT: begin
        op_go = op_idle;  op_sel = OP_RELEASE;
        if (op_fin) st_d = T_DONE;
      end
      T_DONE: begin
        res_valid = 1'b1;
        st_d      = T_IDLE;
      end
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= T_IDLE;  rd_q <= 1'b0;  ten_q <= 1'b0;  nostop_q <= 1'b0;
      reg_q <= 1'b0;  reg16_q <= 1'b0;  pass2_q <= 1'b0;
      addr_q <= '0;  ptr_q <= '0;  cnt_q <= '0;  code_q <= RC_OK;
    end else begin
      st_q <= st_d;  rd_q <= rd_d;  ten_q <= ten_d;  nostop_q <= nostop_d;
      reg_q <= reg_d;  reg16_q <= reg16_d;  pass2_q <= pass2_d;
      addr_q <= addr_d;  ptr_q <= ptr_d;  cnt_q <= cnt_d;  code_q <= code_d;
    end
  end

  i2cseq_op_unit #(.BYTE_W(8)) u_op (
    .clk(clk), .rst_n(rst_n_s),
    .op_go(op_go), .op_sel(op_sel), .tx_byte(tx_byte), .nack_last(nack_last),
    .rx_release(rd_ready), .op_idle(op_idle), .op_fin(op_fin), .op_res(op_res),
    .rx_byte(rd_data), .rx_hold(rd_valid),
    .cmd_valid(bus_cmd_valid), .cmd_code(bus_cmd), .cmd_wbit(bus_cmd_bit),
    .cmd_done(bus_cmd_done), .cmd_rbit(bus_rx_bit), .cmd_stat(bus_status)
  );

  // R10: no second request is taken right after one
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid && req_ready |=> !req_ready);

  // R11: result is a single-cycle pulse
  p_res_single_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |=> !res_valid);

  // R5: a waiting received byte stays put
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R6, R9: abort path only releases the lines
  p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == T_ABORT) && bus_cmd_valid |-> bus_cmd == BC_RELEASE);

  // R8: rejected register request stays off the bus
  p_unsup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == T_DONE) && (code_q == RC_UNSUP) |-> !bus_cmd_valid);

endmodule

// File: tb/tb_i2c_txn_sequencer.sv
module tb_i2c_txn_sequencer;
  localparam int LEN_W = 8;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             req_valid = 0, req_read = 0, req_addr10 = 0, req_no_start = 0;
  logic             req_no_stop = 0, req_reg = 0, req_reg16 = 0, rec_busy = 0;
  logic [9:0]       req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [15:0]      req_reg_ptr = 0;
  logic             req_ready, wr_ready, wr_valid, rd_valid, rd_ready, res_valid;
  logic [7:0]       wr_data, rd_data;
  logic [2:0]       res_code, bus_cmd;
  logic             bus_cmd_valid, bus_cmd_bit;
  logic             bus_cmd_done, bus_rx_bit;
  logic [1:0]       bus_status;

  i2c_txn_sequencer #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_addr10(req_addr10), .req_len(req_len),
    .req_no_start(req_no_start), .req_no_stop(req_no_stop), .req_reg(req_reg),
    .req_reg16(req_reg16), .req_reg_ptr(req_reg_ptr), .rec_busy(rec_busy),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .res_valid(res_valid), .res_code(res_code),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_cmd_bit(bus_cmd_bit),
    .bus_cmd_done(bus_cmd_done), .bus_rx_bit(bus_rx_bit), .bus_status(bus_status)
  );

  int checks = 0, errors = 0;

  // engine + slave model: logs commands, answers read bits from a queue
  logic [2:0] log_cmd [DEPTH];
  logic       log_bit [DEPTH];
  int         log_n = 0;
  logic       rq [DEPTH];
  int         rq_n = 0, rq_p = 0;
  int         fail_idx = -1;
  logic [1:0] fail_stat = 2'd0;
  logic       eng_busy = 0, pend_rb = 1;
  logic [1:0] pend_st = 0;
  int         eng_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 0; bus_cmd_done <= 0; bus_rx_bit <= 1; bus_status <= 0; eng_cnt <= 0;
    end else begin
      bus_cmd_done <= 0;
      if (!eng_busy && !bus_cmd_done && bus_cmd_valid) begin
        if (log_n < DEPTH) begin log_cmd[log_n] <= bus_cmd; log_bit[log_n] <= bus_cmd_bit; end
        log_n   <= log_n + 1;
        pend_st <= (log_n == fail_idx) ? fail_stat : 2'd0;
        if (bus_cmd == 3'd3) begin
          if (rq_p < rq_n) begin pend_rb <= rq[rq_p]; rq_p <= rq_p + 1; end
          else pend_rb <= 1'b1;
        end
        eng_busy <= 1; eng_cnt <= 2;
      end else if (eng_busy) begin
        if (eng_cnt == 0) begin
          bus_cmd_done <= 1; eng_busy <= 0; bus_rx_bit <= pend_rb; bus_status <= pend_st;
        end else eng_cnt <= eng_cnt - 1;
      end
    end
  end

  // write-data source and read-data sink
  logic [7:0] wq [64];
  int wq_n = 0, wq_p = 0;
  assign wr_valid = (wq_p < wq_n);
  assign wr_data  = wq[wq_p % 64];
  always @(posedge clk) if (wr_valid && wr_ready) wq_p <= wq_p + 1;

  logic [3:0] tick = 0;
  logic       slow_rd = 0;
  always @(posedge clk) tick <= tick + 1;
  assign rd_ready = slow_rd ? (tick[1:0] == 2'd0) : 1'b1;

  logic [7:0] rcv [64];
  int rcv_n = 0, res_cnt = 0;
  logic [2:0] last_res = 0;
  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin rcv[rcv_n % 64] <= rd_data; rcv_n <= rcv_n + 1; end
    if (res_valid) begin last_res <= res_code; res_cnt <= res_cnt + 1; end
  end

  // expected command stream
  logic [2:0] e_cmd [256];
  logic       e_bit [256];
  int e_n = 0, log_base = 0, rcv_base = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic e_push(input logic [2:0] c, input logic b);
    e_cmd[e_n] = c; e_bit[e_n] = b; e_n++;
  endtask
  task automatic e_wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) e_push(3'd2, b[i]);
    e_push(3'd3, 1'b1);
  endtask
  task automatic e_rbyte(input logic ackb);
    for (int i = 0; i < 8; i++) e_push(3'd3, 1'b1);
    e_push(3'd2, ackb);
  endtask
  task automatic q_bit(input logic b);
    rq[rq_n] = b; rq_n++;
  endtask
  task automatic q_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) q_bit(b[i]);
  endtask
  task automatic q_wr(input logic [7:0] b);
    wq[wq_n % 64] = b; wq_n++;
  endtask

  task automatic begin_case;
    @(negedge clk);
    e_n = 0; log_base = log_n; rcv_base = rcv_n;
  endtask

  task automatic run(input logic rd, input logic [9:0] a, input logic ten, input int len,
                     input logic ns, input logic np, input logic rg, input logic r16,
                     input logic [15:0] ptr);
    int start_cnt;
    int guard;
    start_cnt = res_cnt;
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    req_read = rd; req_addr = a; req_addr10 = ten; req_len = LEN_W'(len);
    req_no_start = ns; req_no_stop = np; req_reg = rg; req_reg16 = r16; req_reg_ptr = ptr;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (res_cnt == start_cnt && guard < 20000) begin @(negedge clk); guard++; end
    if (res_cnt == start_cnt) check(0, "R11", "watchdog: no result", 0, 1);
  endtask

  task automatic check_stream(input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    check(log_n - log_base == e_n, req, "command count", log_n - log_base, e_n);
    for (int i = 0; i < e_n && i < log_n - log_base; i++) begin
      if (log_cmd[log_base + i] != e_cmd[i] ||
          (e_cmd[i] == 3'd2 && log_bit[log_base + i] != e_bit[i])) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) check(1, req, "command stream", 0, 0);
    else check(0, req, "command stream at index",
               {log_cmd[log_base + first], log_bit[log_base + first]},
               {e_cmd[first], e_bit[first]});
  endtask

  task automatic check_res(input string req, input logic [2:0] exp);
    check(last_res == exp, req, "result code", last_res, exp);
  endtask

  task automatic check_rcv(input string req, input int idx, input logic [7:0] exp);
    check(rcv[(rcv_base + idx) % 64] == exp, req, "received byte", rcv[(rcv_base + idx) % 64], exp);
  endtask

  // scenarios
  task automatic t_reset;
    check(req_ready == 1 && bus_cmd_valid == 0 && res_valid == 0 && rd_valid == 0 && wr_ready == 0,
          "R10", "reset state", {req_ready, bus_cmd_valid, res_valid, rd_valid, wr_ready}, 5'b10000);
  endtask

  task automatic t_write7;  // R1 R2
    begin_case;
    q_wr(8'h3C); q_wr(8'hC3); q_bit(0); q_bit(0); q_bit(0);
    e_push(3'd0, 1); e_wbyte(8'hA0); e_wbyte(8'h3C); e_wbyte(8'hC3); e_push(3'd1, 1);
    run(0, 10'h050, 0, 2, 0, 0, 0, 0, 16'h0);
    check_stream("R1"); check_res("R2", 3'd0);
  endtask

  task automatic t_read7;  // R2 R5
    begin_case;
    slow_rd = 1;
    q_bit(0); q_byte(8'h5A); q_byte(8'h81); q_byte(8'hFF);
    e_push(3'd0, 1); e_wbyte(8'h3B); e_rbyte(0); e_rbyte(0); e_rbyte(1); e_push(3'd1, 1);
    run(1, 10'h01D, 0, 3, 0, 0, 0, 0, 16'h0);
    slow_rd = 0;
    check_stream("R5"); check_res("R5", 3'd0);
    check(rcv_n - rcv_base == 3, "R5", "received count", rcv_n - rcv_base, 3);
    check_rcv("R5", 0, 8'h5A); check_rcv("R5", 1, 8'h81); check_rcv("R5", 2, 8'hFF);
  endtask

  task automatic t_ten_bit;  // R3
    begin_case;
    q_wr(8'h77); q_bit(0); q_bit(0); q_bit(0);
    e_push(3'd0, 1); e_wbyte(8'hF4); e_wbyte(8'hA5); e_wbyte(8'h77); e_push(3'd1, 1);
    run(0, 10'h2A5, 1, 1, 0, 0, 0, 0, 16'h0);
    check_stream("R3"); check_res("R3", 3'd0);
    begin_case;
    q_bit(0); q_bit(0); q_byte(8'h96);
    e_push(3'd0, 1); e_wbyte(8'hF3); e_wbyte(8'hC3); e_rbyte(1); e_push(3'd1, 1);
    run(1, 10'h1C3, 1, 1, 0, 0, 0, 0, 16'h0);
    check_stream("R3"); check_rcv("R3", 0, 8'h96);
  endtask

  task automatic t_raw;  // R4
    begin_case;
    q_wr(8'h11); q_wr(8'h22); q_bit(0); q_bit(0);
    e_wbyte(8'h11); e_wbyte(8'h22);
    run(0, 10'h050, 0, 2, 1, 1, 0, 0, 16'h0);
    check_stream("R4"); check_res("R4", 3'd0);
    begin_case;
    q_byte(8'h3E);
    e_rbyte(1); e_push(3'd1, 1);
    run(1, 10'h050, 0, 1, 1, 0, 0, 0, 16'h0);
    check_stream("R4"); check_rcv("R4", 0, 8'h3E);
  endtask

  task automatic t_nack;  // R6
    begin_case;
    q_bit(1);
    e_push(3'd0, 1); e_wbyte(8'h66); e_push(3'd4, 1);
    run(0, 10'h033, 0, 2, 0, 0, 0, 0, 16'h0);
    check_stream("R6"); check_res("R6", 3'd1);
    begin_case;
    q_wr(8'hAB); q_bit(0); q_bit(1);
    e_push(3'd0, 1); e_wbyte(8'h80); e_wbyte(8'hAB); e_push(3'd4, 1);
    run(0, 10'h040, 0, 2, 0, 0, 0, 0, 16'h0);
    check_stream("R6"); check_res("R6", 3'd2);
  endtask

  task automatic t_reg;  // R7 R8
    begin_case;
    q_bit(0); q_bit(0); q_bit(0); q_bit(0); q_byte(8'hDE); q_byte(8'hAD);
    e_push(3'd0, 1); e_wbyte(8'h90); e_wbyte(8'h12); e_wbyte(8'h34);
    e_push(3'd0, 1); e_wbyte(8'h91); e_rbyte(0); e_rbyte(1); e_push(3'd1, 1);
    run(1, 10'h048, 0, 2, 0, 0, 1, 1, 16'h1234);
    check_stream("R8"); check_res("R7", 3'd0);
    check_rcv("R7", 0, 8'hDE); check_rcv("R7", 1, 8'hAD);
    begin_case;
    q_wr(8'h5E); q_bit(0); q_bit(0); q_bit(0);
    e_push(3'd0, 1); e_wbyte(8'h90); e_wbyte(8'h07); e_wbyte(8'h5E); e_push(3'd1, 1);
    run(0, 10'h048, 0, 1, 0, 0, 1, 0, 16'h0007);
    check_stream("R7"); check_res("R7", 3'd0);
  endtask

  task automatic t_unsup;  // R8
    begin_case;
    run(0, 10'h048, 0, 1, 0, 1, 1, 0, 16'h0001);
    check_stream("R8"); check_res("R8", 3'd5);
    begin_case;
    run(1, 10'h048, 0, 1, 1, 0, 1, 0, 16'h0001);
    check_stream("R8"); check_res("R8", 3'd5);
  endtask

  task automatic t_faults;  // R9
    begin_case;
    q_bit(0);
    fail_idx = log_n + 10; fail_stat = 2'd1;
    e_push(3'd0, 1); e_wbyte(8'h20); e_push(3'd1, 1);
    run(0, 10'h010, 0, 0, 0, 0, 0, 0, 16'h0);
    check_stream("R9"); check_res("R9", 3'd3);
    begin_case;
    fail_idx = log_n + 1; fail_stat = 2'd2;
    e_push(3'd0, 1); e_push(3'd2, 1); e_push(3'd4, 1);
    run(0, 10'h050, 0, 1, 0, 0, 0, 0, 16'h0);
    check_stream("R9"); check_res("R9", 3'd4);
    begin_case;
    fail_idx = log_n; fail_stat = 2'd1;
    e_push(3'd0, 1); e_push(3'd4, 1);
    run(0, 10'h050, 0, 1, 0, 0, 0, 0, 16'h0);
    check_stream("R9"); check_res("R9", 3'd3);
    fail_idx = -1;
  endtask

  task automatic t_busy;  // R10 R11
    int start_cnt;
    int start_log;
    begin_case;
    start_cnt = res_cnt; start_log = log_n;
    rec_busy = 1;
    req_read = 0; req_addr = 10'h050; req_addr10 = 0; req_len = 0;
    req_no_start = 0; req_no_stop = 0; req_reg = 0; req_reg16 = 0;
    req_valid = 1;
    repeat (20) @(negedge clk);
    check(req_ready == 0, "R10", "ready while recovery busy", req_ready, 0);
    check(log_n == start_log && res_cnt == start_cnt, "R10", "no activity while busy",
          log_n - start_log, 0);
    req_valid = 0; rec_busy = 0;
    @(negedge clk);
    check(req_ready == 1, "R10", "ready after recovery", req_ready, 1);
    q_bit(0);
    e_push(3'd0, 1); e_wbyte(8'hA0); e_push(3'd1, 1);
    run(0, 10'h050, 0, 0, 0, 0, 0, 0, 16'h0);
    repeat (5) @(negedge clk);
    check(res_cnt == start_cnt + 1, "R11", "one result per request", res_cnt - start_cnt, 1);
    check_stream("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_write7;
    t_read7;
    t_ten_bit;
    t_raw;
    t_nack;
    t_reg;
    t_unsup;
    t_faults;
    t_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL R11 watchdog expired: actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule